// File: doc/BRIEF.md
# Debug Register Access Chain

This block is a 40-bit scan data register. It sits behind a test access port and gives a debug host indirect access to a small file of internal debug registers. The file holds breakpoint value and control pairs, watchpoint value and control pairs, and a vector-catch register. Each scan shifts in one request: a direction bit, 32 data bits and a 7-bit register address. The request is launched when Update-DR is passed. It completes a fixed number of test clocks later.

The result is pipelined into the following scan. On Capture-DR the chain loads the address and data of the access that the previous scan requested. The direction bit position is reused to return a Ready flag. A host that drives a batch of accesses therefore repeats a scan while Ready reads 0. It closes the batch with a dummy write of 0 to address 0, which pushes out the last result. The comparators that use the registers lie outside this block.

Top module: `dbg_access_chain`

## Requirements
- R1: The chain is 40 bits long and shifts from `tdi` toward `tdo`, least significant bit first. Bit 0 is the direction (1 = write, 0 = read), bits 1 to 32 carry the data, and bits 33 to 39 carry the address. `tdo` always shows bit 0 of the chain.
- R2: An accepted write request stores the data at the addressed register. An accepted read request fetches that register's contents.
- R3: On Capture-DR, bits 39:33 load the address of the last completed access. Bits 32:1 load its data: the written value for a write, or the fetched contents for a read.
- R4: An accepted Update-DR starts an access that completes ACC_LAT test clocks later. Capture-DR loads bit 0 with Ready, which is 0 on any capture edge from the launch edge up to and including the completion edge, and 1 otherwise.
- R5: An Update-DR that arrives while an access is pending is ignored: no request is launched and no register changes.
- R6: Address 0 and every address outside the register map read as 0 and ignore writes. The captured address still echoes the requested address, and a write still echoes its data.
- R7: A reset (active-low `rstN`, sampled on the rising `tck` edge) clears every debug register, clears the result fields to address 0 and data 0, sets Ready to 1, and drives `tdo` to 0.
- R8: Capture-DR, Shift-DR and Update-DR have no effect unless `chainSel` and `extestSel` are both 1.
- R9: The register map is fixed. The vector-catch register is at 0x07. Breakpoint value i is at 0x40+i and breakpoint control i is at 0x50+i, for i < NUM_BKPT (at most 16). Watchpoint value j is at 0x60+j and watchpoint control j is at 0x70+j, for j < NUM_WPT (at most 16). All of them are 32 bits wide and read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Active-low synchronous test-logic reset |
| tdi | input | 1 | Serial data in |
| captureDr | input | 1 | TAP controller is in Capture-DR |
| shiftDr | input | 1 | TAP controller is in Shift-DR |
| updateDr | input | 1 | TAP controller is in Update-DR |
| chainSel | input | 1 | The scan-chain select matches this chain |
| extestSel | input | 1 | The instruction register holds the access qualifier |
| tdo | output | 1 | Serial data out (bit 0 of the chain) |

## Verification
A wrong register value cannot be seen on the ports until a later scan asks for it. It then appears one scan late, in the captured data field. The bench therefore writes, reads back and flushes each register class, including the unmapped addresses and address 0. A wrong pending-access count shows up on the very next capture as a Ready bit that is wrong, or that is right one clock early or one clock late. Ready is checked at exactly ACC_LAT-1 and ACC_LAT idle clocks. A tracking model of the chain is compared with `tdo` on every falling edge, so a wrong bit is caught within one clock of being shifted.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 7;
  localparam int CHAIN_W = 1 + DATA_W + ADDR_W;

  // register map bases; neighbours decode these
  localparam logic [ADDR_W-1:0] VCR_ADDR = 7'h07;
  localparam logic [ADDR_W-1:0] BVR_BASE = 7'h40;
  localparam logic [ADDR_W-1:0] BCR_BASE = 7'h50;
  localparam logic [ADDR_W-1:0] WVR_BASE = 7'h60;
  localparam logic [ADDR_W-1:0] WCR_BASE = 7'h70;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic shift;
    logic launch;
    logic complete;
  } chainStb_t;
endpackage

// File: rtl/dbg_chain_ctrl.sv
module dbg_chain_ctrl
  import dbg_chain_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic      tck,
  input  logic      rstN,
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  input  logic      chainSel,
  input  logic      extestSel,
  output chainStb_t stb,
  output logic      busy
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LAT - 1);

  logic             selected;
  logic [CNT_W-1:0] waitCnt;

  assign selected = chainSel & extestSel;

  always_comb begin
    stb.capture  = captureDr & selected;
    stb.shift    = shiftDr & selected;
    stb.launch   = updateDr & selected & ~busy;
    stb.complete = busy & (waitCnt == '0);
  end

  always_ff @(posedge tck) begin
    if (!rstN) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (stb.launch) begin
      busy    <= 1'b1;
      waitCnt <= CNT_LOAD;
    end else if (stb.complete) begin
      busy    <= 1'b0;
    end else if (busy) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/dbg_chain_dp.sv
module dbg_chain_dp
  import dbg_chain_pkg::*;
(
  input  logic              tck,
  input  logic              rstN,
  input  chainStb_t         stb,
  input  logic              busy,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rdData,
  output logic              tdo,
  output logic              reqWr,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData
);
  logic [CHAIN_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  resAddr;
  logic [DATA_W-1:0]  resData;

  assign tdo = shiftReg[0];

  always_ff @(posedge tck) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.capture) begin
      shiftReg <= {resAddr, resData, ~busy};
    end else if (stb.shift) begin
      shiftReg <= {tdi, shiftReg[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (!rstN) begin
      reqWr   <= 1'b0;
      reqAddr <= '0;
      reqData <= '0;
    end else if (stb.launch) begin
      reqWr   <= shiftReg[0];
      reqData <= shiftReg[DATA_W:1];
      reqAddr <= shiftReg[CHAIN_W-1:DATA_W+1];
    end
  end

  always_ff @(posedge tck) begin
    if (!rstN) begin
      resAddr <= '0;
      resData <= '0;
    end else if (stb.complete) begin
      resAddr <= reqAddr;
      resData <= reqWr ? reqData : rdData;
    end
  end
endmodule

// File: rtl/dbg_chain_regs.sv
module dbg_chain_regs
  import dbg_chain_pkg::*;
#(
  parameter int NUM_BKPT = 16,
  parameter int NUM_WPT  = 4
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] vcrReg;
  logic [DATA_W-1:0] bkptVal [NUM_BKPT];
  logic [DATA_W-1:0] bkptCtl [NUM_BKPT];
  logic [DATA_W-1:0] wptVal  [NUM_WPT];
  logic [DATA_W-1:0] wptCtl  [NUM_WPT];

  always_ff @(posedge tck) begin
    if (!rstN) begin
      vcrReg <= '0;
      for (int i = 0; i < NUM_BKPT; i++) begin
        bkptVal[i] <= '0;
        bkptCtl[i] <= '0;
      end
      for (int j = 0; j < NUM_WPT; j++) begin
        wptVal[j] <= '0;
        wptCtl[j] <= '0;
      end
    end else if (wrEn) begin
      if (addr == VCR_ADDR) vcrReg <= wrData;
      for (int i = 0; i < NUM_BKPT; i++) begin
        if (addr == BVR_BASE + ADDR_W'(i)) bkptVal[i] <= wrData;
        if (addr == BCR_BASE + ADDR_W'(i)) bkptCtl[i] <= wrData;
      end
      for (int j = 0; j < NUM_WPT; j++) begin
        if (addr == WVR_BASE + ADDR_W'(j)) wptVal[j] <= wrData;
        if (addr == WCR_BASE + ADDR_W'(j)) wptCtl[j] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == VCR_ADDR) rdData = vcrReg;
    for (int i = 0; i < NUM_BKPT; i++) begin
      if (addr == BVR_BASE + ADDR_W'(i)) rdData = bkptVal[i];
      if (addr == BCR_BASE + ADDR_W'(i)) rdData = bkptCtl[i];
    end
    for (int j = 0; j < NUM_WPT; j++) begin
      if (addr == WVR_BASE + ADDR_W'(j)) rdData = wptVal[j];
      if (addr == WCR_BASE + ADDR_W'(j)) rdData = wptCtl[j];
    end
  end
endmodule

// File: rtl/dbg_access_chain.sv
module dbg_access_chain
  import dbg_chain_pkg::*;
#(
  parameter int NUM_BKPT = 16,
  parameter int NUM_WPT  = 4,
  parameter int ACC_LAT  = 4
) (
  input  logic tck,
  input  logic rstN,
  input  logic tdi,
  input  logic captureDr,
  input  logic shiftDr,
  input  logic updateDr,
  input  logic chainSel,
  input  logic extestSel,
  output logic tdo
);
  chainStb_t         stb;
  logic              busy;
  logic              reqWr;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [DATA_W-1:0] rdData;

  dbg_chain_ctrl #(.ACC_LAT(ACC_LAT)) u_ctrl (
    .tck(tck), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .chainSel(chainSel), .extestSel(extestSel),
    .stb(stb), .busy(busy)
  );

  dbg_chain_dp u_dp (
    .tck(tck), .rstN(rstN), .stb(stb), .busy(busy), .tdi(tdi),
    .rdData(rdData), .tdo(tdo), .reqWr(reqWr), .reqAddr(reqAddr),
    .reqData(reqData)
  );

  dbg_chain_regs #(.NUM_BKPT(NUM_BKPT), .NUM_WPT(NUM_WPT)) u_regs (
    .tck(tck), .rstN(rstN), .wrEn(stb.complete & reqWr), .addr(reqAddr),
    .wrData(reqData), .rdData(rdData)
  );
endmodule

// File: rtl/dbg_access_chain_chk.sv
module dbg_access_chain_chk
  import dbg_chain_pkg::*;
(
  input logic              tck,
  input logic              rstN,
  input logic              updateDr,
  input logic              chainSel,
  input logic              extestSel,
  input logic              busy,
  input logic              complete,
  input logic              reqWr,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic [DATA_W-1:0] rdData
);
  // R5
  a_r5_pending_update_ignored: assert property (@(posedge tck) disable iff (!rstN)
    (busy && updateDr && chainSel && extestSel)
      |=> ($stable(reqAddr) && $stable(reqData) && $stable(reqWr)));

  // R8
  a_r8_unselected_update_ignored: assert property (@(posedge tck) disable iff (!rstN)
    (!busy && updateDr && !(chainSel && extestSel))
      |=> ($stable(reqAddr) && $stable(reqData) && $stable(reqWr)));

  // R4
  a_r4_launch_marks_pending: assert property (@(posedge tck) disable iff (!rstN)
    (!busy && updateDr && chainSel && extestSel) |=> busy);

  // R4
  a_r4_complete_frees: assert property (@(posedge tck) disable iff (!rstN)
    complete |=> !busy);

  // R6
  a_r6_addr_zero_reads_zero: assert property (@(posedge tck) disable iff (!rstN)
    (complete && reqAddr == '0) |-> (rdData == '0));
endmodule

bind dbg_access_chain dbg_access_chain_chk u_chk (
  .tck(tck), .rstN(rstN), .updateDr(updateDr), .chainSel(chainSel),
  .extestSel(extestSel), .busy(busy), .complete(stb.complete),
  .reqWr(reqWr), .reqAddr(reqAddr), .reqData(reqData), .rdData(rdData)
);

// File: tb/dbg_access_chain_tb.sv
module dbg_access_chain_tb;
  localparam int NBK = 16;
  localparam int NWP = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tdi = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic chainSel = 1'b1, extestSel = 1'b1;
  logic tdo;
  int   tests = 0, fails = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  dbg_access_chain #(.NUM_BKPT(NBK), .NUM_WPT(NWP), .ACC_LAT(LAT)) u_dut (
    .tck(clk), .rstN(rstN), .tdi(tdi), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .chainSel(chainSel), .extestSel(extestSel), .tdo(tdo)
  );

  // behavioural reference model
  logic [39:0] mChain;
  logic [31:0] mRegs [128];
  logic [31:0] mReqD, mResD;
  logic [6:0]  mReqA, mResA;
  logic        mReqWr;
  int          mPending;

  function automatic bit mapped(input int a);
    return (a == 7) || (a >= 64 && a < 64 + NBK) || (a >= 80 && a < 80 + NBK) ||
           (a >= 96 && a < 96 + NWP) || (a >= 112 && a < 112 + NWP);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mChain = '0; mPending = 0; mResA = '0; mResD = '0;
      mReqWr = 1'b0; mReqA = '0; mReqD = '0;
      for (int k = 0; k < 128; k++) mRegs[k] = '0;
    end else begin
      automatic bit          sel = chainSel && extestSel;
      automatic int          oldPend = mPending;
      automatic logic [39:0] oldChain = mChain;
      if (sel && captureDr) mChain = {mResA, mResD, oldPend == 0};
      else if (sel && shiftDr) mChain = {tdi, oldChain[39:1]};
      if (oldPend > 0) begin
        mPending = oldPend - 1;
        if (mPending == 0) begin
          if (mReqWr) begin
            if (mapped(int'(mReqA))) mRegs[mReqA] = mReqD;
            mResD = mReqD;
          end else begin
            mResD = mapped(int'(mReqA)) ? mRegs[mReqA] : 32'h0;
          end
          mResA = mReqA;
        end
      end
      if (sel && updateDr && oldPend == 0) begin
        mReqWr = oldChain[0]; mReqD = oldChain[32:1]; mReqA = oldChain[39:33];
        mPending = LAT;
      end
    end
  end

  // every-clock comparison of the serial output
  always @(negedge clk) begin
    if (rstN && !finished) begin
      tests++;
      if (tdo !== mChain[0]) begin
        fails++;
        $display("FAIL R1 tdo per-clock: got %0b expected %0b", tdo, mChain[0]);
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expectScan(input string tag, input logic [39:0] got, input logic rdy,
                            input logic [6:0] a, input logic [31:0] d);
    check({tag, " ready"}, 64'(got[0]), 64'(rdy));
    check({tag, " data"}, 64'(got[32:1]), 64'(d));
    check({tag, " addr"}, 64'(got[39:33]), 64'(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scan(input bit wr, input logic [31:0] d, input logic [6:0] a,
                      output logic [39:0] got);
    logic [39:0] req;
    req = {a, d, wr};
    captureDr = 1'b1; @(negedge clk);
    captureDr = 1'b0; shiftDr = 1'b1;
    for (int i = 0; i < 40; i++) begin
      got[i] = tdo;
      tdi = req[i];
      @(negedge clk);
    end
    shiftDr = 1'b0; updateDr = 1'b1; @(negedge clk);
    updateDr = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; idle(3); rstN = 1'b1;
  endtask

  initial begin
    logic [39:0] g;
    @(negedge clk);
    doReset();
    check("R7 tdo after reset", 64'(tdo), 64'd0);
    // R7 first capture after reset, then R2 write of a breakpoint value
    scan(1, 32'hA5A5_0001, 7'h40, g); expectScan("R7 reset capture", g, 1, 7'h00, 32'h0); idle(4);
    scan(0, 32'h0, 7'h40, g);         expectScan("R3 write echo", g, 1, 7'h40, 32'hA5A5_0001); idle(4);
    scan(1, 32'h0000_00FF, 7'h07, g); expectScan("R2 read contents", g, 1, 7'h40, 32'hA5A5_0001); idle(4);
    scan(1, 32'h0000_1234, 7'h00, g); expectScan("R9 vector catch echo", g, 1, 7'h07, 32'h0000_00FF); idle(4);
    scan(0, 32'h0, 7'h00, g);         expectScan("R6 addr0 write echo", g, 1, 7'h00, 32'h0000_1234); idle(4);
    scan(1, 32'h0000_C0DE, 7'h73, g); expectScan("R6 addr0 reads zero", g, 1, 7'h00, 32'h0); idle(4);
    scan(0, 32'h0, 7'h7F, g);         expectScan("R9 watch control echo", g, 1, 7'h73, 32'h0000_C0DE); idle(4);
    scan(1, 32'hFFFF_FFFF, 7'h7F, g); expectScan("R6 unmapped read zero", g, 1, 7'h7F, 32'h0); idle(4);
    scan(0, 32'h0, 7'h7F, g);         expectScan("R6 unmapped write echo", g, 1, 7'h7F, 32'hFFFF_FFFF);
    // R4 capture straight after update: not ready
    scan(0, 32'h0, 7'h73, g);         check("R4 ready low right after update", 64'(g[0]), 64'd0); idle(4);
    scan(0, 32'h0, 7'h40, g);         expectScan("R2 watch control readback", g, 1, 7'h73, 32'h0000_C0DE);
    idle(LAT - 1);
    scan(1, 32'h0000_0001, 7'h50, g); check("R4 ready low at latency-1 idle", 64'(g[0]), 64'd0);
    idle(LAT);
    scan(1, 32'h0000_0003, 7'h07, g); expectScan("R4 ready high at latency idle", g, 1, 7'h50, 32'h0000_0001);
    // R5: a garbled request (write 0x8000_0001 to 0x43) offered while pending
    shiftDr = 1'b1; tdi = 1'b1; @(negedge clk);
    shiftDr = 1'b0; updateDr = 1'b1; @(negedge clk);
    updateDr = 1'b0; idle(4);
    scan(0, 32'h0, 7'h43, g);         expectScan("R5 first access completes", g, 1, 7'h07, 32'h0000_0003); idle(4);
    scan(0, 32'h0, 7'h07, g);         expectScan("R5 pending update ignored", g, 1, 7'h43, 32'h0); idle(4);
    scan(1, 32'h0, 7'h00, g);         expectScan("R9 vector catch readback", g, 1, 7'h07, 32'h0000_0003); idle(4);
    // R8: unselected scans change nothing
    chainSel = 1'b0; scan(1, 32'h0000_DEAD, 7'h41, g); idle(4);
    chainSel = 1'b1; extestSel = 1'b0; scan(1, 32'h0000_BEEF, 7'h41, g); idle(4);
    extestSel = 1'b1;
    scan(0, 32'h0, 7'h41, g);         expectScan("R8 result unchanged", g, 1, 7'h00, 32'h0); idle(4);
    scan(1, 32'h0, 7'h00, g);         expectScan("R8 register untouched", g, 1, 7'h41, 32'h0); idle(4);
    // R7: reset clears registers
    scan(1, 32'h0000_0077, 7'h52, g); idle(4);
    doReset();
    scan(0, 32'h0, 7'h52, g);         expectScan("R7 capture after mid reset", g, 1, 7'h00, 32'h0); idle(4);
    scan(1, 32'h0, 7'h00, g);         expectScan("R7 control cleared", g, 1, 7'h52, 32'h0); idle(4);
    // R9: edges of the breakpoint and watchpoint ranges
    scan(1, 32'h0000_5F5F, 7'h5F, g); idle(4);
    scan(1, 32'h0000_6060, 7'h60, g); idle(4);
    scan(0, 32'h0, 7'h5F, g);         expectScan("R9 watch value echo", g, 1, 7'h60, 32'h0000_6060); idle(4);
    scan(0, 32'h0, 7'h60, g);         expectScan("R9 last breakpoint control", g, 1, 7'h5F, 32'h0000_5F5F); idle(4);
    scan(1, 32'h0, 7'h00, g);         expectScan("R9 first watch value", g, 1, 7'h60, 32'h0000_6060); idle(4);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule